// File: doc/BRIEF.md
# Lockable Thermal Throttle Controller

This block turns on-die temperature-zone flags into two platform actions: a throttle-request level for the clock and power reduction logic, and an active-low thermal-trip output that brings the platform down on a catastrophic temperature. An 8-bit configuration register, written and read through a simple port, holds a master enable, a choice of catastrophic source, a choice of which zones cause throttling, a halt-on-catastrophic switch and a write-once lock.

The throttle request is combinational: it follows the zone flags through the enabled zone set. The trip output is registered and sticky. Once it asserts, it holds until hardware reset, even after the catastrophic condition clears. Setting the lock freezes every other configuration bit until hardware reset. The write that sets the lock also loads the other bits, so firmware can configure and lock in one access.

Top module: `thermal_guard`

## Requirements
- R1: After reset the configuration reads 0x00, `tripN` is high, `tripLatched` is low and `throttleReq` is low.
- R2: Bits 6, 2 and 1 of the configuration always read as 0, whatever value is written to them.
- R3: When bit 7 (enable) is 0, `throttleReq` stays low and `tripN` never asserts, whatever the zone inputs do.
- R4: Bit 5 selects the catastrophic source. When it is 1, `catDirect` is used and `zoneCatCmp` is ignored. When it is 0, `zoneCatCmp` is used and `catDirect` is ignored.
- R5: With enable set, `throttleReq` is high when `zoneHot` or the selected catastrophic source is high. When bit 4 is 0, `zoneAux2` also raises it. When bit 4 is 1, `zoneAux2` is ignored.
- R6: With enable (bit 7) and halt (bit 3) both set, a high on the selected catastrophic source drives `tripN` low on the next rising clock edge. With halt at 0, `tripN` stays high.
- R7: Once `tripN` is low, it stays low, and `tripLatched` stays high, until reset, even after the catastrophic source returns low.
- R8: Writing 1 to bit 0 sets the lock. Writing 0 to bit 0 leaves it unchanged. Only reset clears it.
- R9: While the lock is set, writes leave bits 7 to 1 unchanged. The write that sets the lock also stores bits 7 to 1.
- R10: `cfgRdData` shows the stored configuration one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Stored configuration, reserved bits zero |
| zoneHot | input | 1 | Hot zone flag |
| zoneAux2 | input | 1 | Auxiliary-2 zone flag |
| zoneCatCmp | input | 1 | Catastrophic flag from threshold comparison |
| catDirect | input | 1 | Direct catastrophic trip from the sensor circuit |
| throttleReq | output | 1 | Throttle request level |
| tripN | output | 1 | Latched active-low thermal trip |
| tripLatched | output | 1 | Test view of the latched trip state |

## Verification
The bench targets these faults:
- **Source swap.** A design that swapped the catastrophic sources would throttle on `catDirect` while bit 5 is clear.
- **Zone-select ignored.** A design that ignored zone select would keep throttling on `zoneAux2` with bit 4 set.
- **Trip not sticky.** A trip that was not sticky would release `tripN` when the catastrophic pulse ends. The bench pulses the source for a single cycle and checks that `tripN` stays low afterwards.
- **Weak lock.** After locking, the bench writes new data with bit 0 clear. A weak lock would either drop bit 0 or let the new zone selection through, and the bench sees either change both on readback and on `throttleReq`.
- **Trip ignores enable.** The bench holds `zoneCatCmp` high with halt set but enable clear, and checks that `tripN` stays high.

// File: rtl/tguard_pkg.sv
package tguard_pkg;
  localparam int CFG_W     = 8;
  localparam int EN_BIT    = 7;
  localparam int SRC_BIT   = 5;
  localparam int ZSEL_BIT  = 4;
  localparam int HALT_BIT  = 3;
  localparam int LOCK_BIT  = 0;

  typedef struct packed {
    logic loadCfg;
    logic setLock;
  } cfgStrobe_t;
endpackage

// File: rtl/tguard_ctrl.sv
module tguard_ctrl
  import tguard_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         locked,
  output cfgStrobe_t   strobe
);
  always_comb begin
    strobe.loadCfg = wrEn & ~locked;
    strobe.setLock = wrEn & wrData[LOCK_BIT] & ~locked;
  end
endmodule

// File: rtl/tguard_dp.sv
module tguard_dp
  import tguard_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  cfgStrobe_t   strobe,
  input  logic [W-1:0] wrData,
  input  logic         zoneHot,
  input  logic         zoneAux2,
  input  logic         zoneCatCmp,
  input  logic         catDirect,
  output logic [W-1:0] rdData,
  output logic         locked,
  output logic         throttleReq,
  output logic         tripN,
  output logic         tripLatched
);
  logic enableQ, srcQ, zselQ, haltQ, lockQ, tripQ;
  logic catSel, tripSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      srcQ    <= 1'b0;
      zselQ   <= 1'b0;
      haltQ   <= 1'b0;
    end else if (strobe.loadCfg) begin
      enableQ <= wrData[EN_BIT];
      srcQ    <= wrData[SRC_BIT];
      zselQ   <= wrData[ZSEL_BIT];
      haltQ   <= wrData[HALT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockQ <= 1'b0;
    else if (strobe.setLock) lockQ <= 1'b1;
  end

  always_comb begin
    catSel      = srcQ ? catDirect : zoneCatCmp;
    tripSet     = enableQ & haltQ & catSel;
    throttleReq = enableQ & (zoneHot | catSel | (zoneAux2 & ~zselQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tripQ <= 1'b0;
    else if (tripSet) tripQ <= 1'b1;
  end

  always_comb begin
    rdData           = '0;
    rdData[EN_BIT]   = enableQ;
    rdData[SRC_BIT]  = srcQ;
    rdData[ZSEL_BIT] = zselQ;
    rdData[HALT_BIT] = haltQ;
    rdData[LOCK_BIT] = lockQ;
  end

  assign locked      = lockQ;
  assign tripN       = ~tripQ;
  assign tripLatched = tripQ;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import tguard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             zoneHot,
  input  logic             zoneAux2,
  input  logic             zoneCatCmp,
  input  logic             catDirect,
  output logic             throttleReq,
  output logic             tripN,
  output logic             tripLatched
);
  cfgStrobe_t strobe;
  logic       locked;

  tguard_ctrl #(.W(CFG_W)) ctrl_i (
    .wrEn(cfgWrEn), .wrData(cfgWrData), .locked(locked), .strobe(strobe)
  );

  tguard_dp #(.W(CFG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .zoneHot(zoneHot), .zoneAux2(zoneAux2), .zoneCatCmp(zoneCatCmp),
    .catDirect(catDirect), .rdData(cfgRdData), .locked(locked),
    .throttleReq(throttleReq), .tripN(tripN), .tripLatched(tripLatched)
  );
endmodule

// File: rtl/tguard_chk.sv
module tguard_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgRdData,
  input logic       zoneCatCmp,
  input logic       catDirect,
  input logic       throttleReq,
  input logic       tripN,
  input logic       tripLatched
);
  logic catPick;
  assign catPick = cfgRdData[5] ? catDirect : zoneCatCmp;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN) (cfgRdData & 8'h46) == 8'h00); // R2
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN) !cfgRdData[7] |-> !throttleReq); // R3
  AST_TRIP_SET: assert property (@(posedge clk) disable iff (!rstN) (cfgRdData[7] && cfgRdData[3] && catPick) |=> !tripN); // R6
  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rstN) $rose(tripLatched) |-> $past(cfgRdData[7] && cfgRdData[3])); // R6
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rstN) !tripN |=> !tripN); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN) cfgRdData[0] |=> $stable(cfgRdData)); // R9
endmodule

bind thermal_guard tguard_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .zoneCatCmp(zoneCatCmp),
  .catDirect(catDirect), .throttleReq(throttleReq), .tripN(tripN),
  .tripLatched(tripLatched)
);

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       zoneHot = 1'b0, zoneAux2 = 1'b0, zoneCatCmp = 1'b0, catDirect = 1'b0;
  logic       throttleReq, tripN, tripLatched;
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  thermal_guard dut_i (.*);

  // {cfg[7:0], hot, aux2, cmp, direct, expected throttle}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {8'h00, 4'b1111, 1'b0},  // R3 disabled
    {8'h80, 4'b1000, 1'b1},  // R5 hot
    {8'h80, 4'b0100, 1'b1},  // R5 aux2 counted
    {8'h90, 4'b0100, 1'b0},  // R5 aux2 ignored
    {8'h90, 4'b1000, 1'b1},  // R5 hot with zsel
    {8'h80, 4'b0010, 1'b1},  // R4 compare source
    {8'h80, 4'b0001, 1'b0},  // R4 direct ignored
    {8'hA0, 4'b0001, 1'b1},  // R4 direct source
    {8'hA0, 4'b0010, 1'b0},  // R4 compare ignored
    {8'h80, 4'b0000, 1'b0}   // R5 no zone
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic setZones(input logic [3:0] z);
    {zoneHot, zoneAux2, zoneCatCmp, catDirect} = z;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; setZones(4'b0000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cfg", cfgRdData, 8'h00);
    chk("R1 tripN", {7'd0, tripN}, 8'h01);
    chk("R1 latched", {7'd0, tripLatched}, 8'h00);
    chk("R1 throttle", {7'd0, throttleReq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][12:5]);
      setZones(VEC[i][4:1]);
      #1;
      chk("R10 readback", cfgRdData, VEC[i][12:5]);
      chk("R3/R4/R5 throttle", {7'd0, throttleReq}, {7'd0, VEC[i][0]});
      setZones(4'b0000);
    end

    // R2 reserved bits
    wr(8'hFE);
    chk("R2 reserved", cfgRdData, 8'hB8);

    // R6 halt clear: no trip
    doReset();
    wr(8'h80); setZones(4'b0010);
    repeat (3) @(negedge clk);
    chk("R6 no halt", {7'd0, tripN}, 8'h01);

    // R3 enable clear: no trip
    doReset();
    wr(8'h08); setZones(4'b0011);
    repeat (3) @(negedge clk);
    chk("R3 no trip", {7'd0, tripN}, 8'h01);

    // R6/R7 compare-source trip with single-cycle pulse
    doReset();
    wr(8'h88);
    setZones(4'b0010);
    #1 chk("R6 before edge", {7'd0, tripN}, 8'h01);
    @(negedge clk);
    chk("R6 trip asserted", {7'd0, tripN}, 8'h00);
    setZones(4'b0000);
    repeat (4) @(negedge clk);
    chk("R7 sticky tripN", {7'd0, tripN}, 8'h00);
    chk("R7 sticky latched", {7'd0, tripLatched}, 8'h01);
    doReset();
    chk("R7 reset clears", {7'd0, tripN}, 8'h01);

    // R4 direct-source trip, compare ignored
    wr(8'hA8);
    setZones(4'b0010);
    @(negedge clk);
    chk("R4 cmp ignored for trip", {7'd0, tripN}, 8'h01);
    setZones(4'b0001);
    @(negedge clk);
    chk("R4 direct trip", {7'd0, tripN}, 8'h00);

    // R8/R9 lock
    doReset();
    wr(8'h81);
    chk("R9 config with lock", cfgRdData, 8'h81);
    wr(8'h10);
    chk("R8 zero write keeps lock", cfgRdData, 8'h81);
    setZones(4'b0100);
    #1 chk("R9 zsel frozen", {7'd0, throttleReq}, 8'h01);
    setZones(4'b0000);
    wr(8'h39);
    chk("R9 locked write", cfgRdData, 8'h81);
    doReset();
    chk("R8 reset unlocks", cfgRdData, 8'h00);
    wr(8'h90);
    chk("R8 writable after reset", cfgRdData, 8'h90);

    finishUp();
  end
endmodule